// File: doc/BRIEF.md
# Run-State Controller for a Serial Engine

This block holds the operating state of a serial engine (reset, run or pause) and moves the engine between those states through a handshake between two clock domains. Software writes a target state through a small register port. The block then lowers a valid indication until the new state has settled in both the register clock domain and the engine clock domain. Only after that does the readable state field show the new value.

The block also gathers the engine's FIFO status lines, its two service events and a parameterised set of error events into readable registers. The events are kept as sticky write-one-to-clear flags, and any latched error raises a level interrupt. A latched error pulls the engine back to reset as soon as no transition is in flight. A software reset write clears the flags, pulses a FIFO/counter clear toward the engine and returns the state to reset. A flush request carried in a state write gives a one-cycle flush pulse. All engine status and event inputs are taken to be synchronous to the register clock. Only the state handoff crosses into the engine clock.

Top module: `rsc_top`

## Requirements
- R1: The state field is bits [1:0] of the state register (address 0), with RESET = 0, RUN = 1 and PAUSE = 3. A state write carrying code 2 has no effect: valid stays high and the state field keeps its value.
- R2: A state write accepted while valid (bit 2 of the state register) is high drives valid low from the next cycle on. Valid stays low for at least BUS_SETTLE register clock cycles. The state field keeps its old value until valid returns high and then shows the written code.
- R3: By the time valid returns high, the engine-domain outputs match the new state: `eng_run` is high only for RUN and `eng_pause` is high only for PAUSE.
- R4: A state write made while valid is low is ignored. The state that settles is the one from the earlier accepted write.
- R5: An accepted state write with bit 6 set produces a single-cycle `flush_pulse` on the cycle after the write.
- R6: Writing 1 to bit 0 of the software reset register (address 1) pulses `fifo_clear` for one cycle and clears every service and error flag. It then returns the state to RESET, waiting for any transition in flight to finish first.
- R7: The operational register (address 2) shows the live inputs at fixed bits: output-not-empty at bit 4, input-not-empty at bit 5, output-full at bit 6, output-done at bit 10 and input-done at bit 11.
- R8: The output and input service events are sticky at bits 8 and 9 of the operational register. Writing 1 to a bit clears it, and writing 0 leaves it set.
- R9: Each error event sets a sticky bit in the error register (address 3, bit i for event i). Writing 1 clears it. `irq` is high exactly while any error bit is set.
- R10: When an error is latched, valid is high and the state is not RESET, valid drops on the next cycle and the state settles to RESET.
- R11: After reset the state is RESET, valid is high, all flags and `irq` are low, and both engine enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-side clock |
| rst_n | input | 1 | Active-low reset, register domain |
| eng_clk | input | 1 | Engine clock |
| eng_rst_n | input | 1 | Active-low reset, engine domain |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for both read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| out_not_empty | input | 1 | Engine output FIFO holds data |
| in_not_empty | input | 1 | Engine input FIFO holds data |
| out_full | input | 1 | Engine output FIFO is full |
| out_done | input | 1 | Engine output count reached |
| in_done | input | 1 | Engine input count reached |
| out_svc_set | input | 1 | Output service event (one-cycle set) |
| in_svc_set | input | 1 | Input service event (one-cycle set) |
| err_set | input | ERR_W | Error events, one bit per source |
| irq | output | 1 | Level interrupt, high while any error is latched |
| flush_pulse | output | 1 | One-cycle request to flush pending FIFO content |
| fifo_clear | output | 1 | One-cycle FIFO and counter clear from software reset |
| eng_run | output | 1 | Engine-domain enable, state is RUN |
| eng_pause | output | 1 | Engine-domain hold, state is PAUSE |

## Verification
The bench builds the block with BUS_SETTLE = 3, ENG_SETTLE = 3, SYNC_STAGES = 2 and five error sources. It runs an engine clock that is not a multiple of the register clock, so the handshake lands on different phase relations from one transition to the next. Because the window is short, every pair of starting state and written code, the illegal code included, can be swept completely. The bench also sweeps all 32 status input patterns, every service clear mask and every single error source. Error forcing, software reset during a transition and writes made inside the window are then covered on top of that sweep.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

   typedef enum logic [1:0] {
      ST_RESET = 2'd0,
      ST_RUN   = 2'd1,
      ST_PAUSE = 2'd3
   } run_state_e;

   localparam int A_STATE = 0;
   localparam int A_SWRST = 1;
   localparam int A_OPER  = 2;
   localparam int A_ERR   = 3;

   localparam int B_VALID    = 2;
   localparam int B_FLUSH    = 6;
   localparam int B_OUT_NE   = 4;
   localparam int B_IN_NE    = 5;
   localparam int B_OUT_FULL = 6;
   localparam int B_OUT_SVC  = 8;
   localparam int B_IN_SVC   = 9;
   localparam int B_OUT_DONE = 10;
   localparam int B_IN_DONE  = 11;

   localparam logic [1:0] CODE_ILLEGAL = 2'd2;

endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] ff_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= '0;
            else        ff_q <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= '0;
            else        ff_q <= {ff_q[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = ff_q[STAGES-1];
endmodule

// File: rtl/rsc_flag_bank.sv
module rsc_flag_bank #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         w1c_we,
   input  logic [W-1:0] w1c_mask,
   input  logic         clr_all,
   output logic [W-1:0] flags_q
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      flags_q[i] <= 1'b0;
            else if (clr_all)                flags_q[i] <= 1'b0;
            else if (set_i[i])               flags_q[i] <= 1'b1;
            else if (w1c_we && w1c_mask[i])  flags_q[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/rsc_seq.sv
module rsc_seq
   import rsc_pkg::*;
#(
   parameter int BUS_SETTLE  = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       launch,
   input  run_state_e launch_code,
   input  logic       ack_tgl,
   output logic       busy,
   output run_state_e cur_st,
   output run_state_e tgt_st,
   output logic       req_tgl
);
   localparam int BCW = $clog2(BUS_SETTLE + 1);

   typedef enum logic [1:0] {P_IDLE, P_COUNT, P_WAIT} phase_e;

   phase_e         phase_q;
   logic [BCW-1:0] bcnt_q;
   logic           ack_s;

   rsc_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ack_tgl),
      .q     (ack_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= P_IDLE;
         bcnt_q  <= '0;
         cur_st  <= ST_RESET;
         tgt_st  <= ST_RESET;
         req_tgl <= 1'b0;
      end else begin
         unique case (phase_q)
            P_IDLE: begin
               if (launch) begin
                  tgt_st  <= launch_code;
                  bcnt_q  <= '0;
                  phase_q <= P_COUNT;
               end
            end
            P_COUNT: begin
               if (bcnt_q == BCW'(BUS_SETTLE - 1)) begin
                  req_tgl <= ~req_tgl;
                  phase_q <= P_WAIT;
               end else begin
                  bcnt_q <= bcnt_q + 1'b1;
               end
            end
            P_WAIT: begin
               if (ack_s == req_tgl) begin
                  cur_st  <= tgt_st;
                  phase_q <= P_IDLE;
               end
            end
            default: phase_q <= P_IDLE;
         endcase
      end
   end

   assign busy = (phase_q != P_IDLE);
endmodule

// File: rtl/rsc_eng_side.sv
module rsc_eng_side
   import rsc_pkg::*;
#(
   parameter int ENG_SETTLE  = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic       eng_clk,
   input  logic       eng_rst_n,
   input  logic       req_tgl,
   input  run_state_e tgt_st,
   output logic       ack_tgl,
   output logic       run,
   output logic       pause
);
   localparam int ECW = $clog2(ENG_SETTLE + 1);

   logic           req_s;
   logic           act_q;
   logic [ECW-1:0] ecnt_q;
   run_state_e     st_q;

   rsc_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk   (eng_clk),
      .rst_n (eng_rst_n),
      .d     (req_tgl),
      .q     (req_s)
   );

   always_ff @(posedge eng_clk or negedge eng_rst_n) begin
      if (!eng_rst_n) begin
         act_q   <= 1'b0;
         ecnt_q  <= '0;
         st_q    <= ST_RESET;
         ack_tgl <= 1'b0;
      end else if (!act_q) begin
         if (req_s != ack_tgl) begin
            act_q  <= 1'b1;
            ecnt_q <= '0;
         end
      end else if (ecnt_q == ECW'(ENG_SETTLE - 1)) begin
         act_q   <= 1'b0;
         st_q    <= tgt_st;
         ack_tgl <= ~ack_tgl;
      end else begin
         ecnt_q <= ecnt_q + 1'b1;
      end
   end

   assign run   = (st_q == ST_RUN);
   assign pause = (st_q == ST_PAUSE);
endmodule

// File: rtl/rsc_top.sv
module rsc_top
   import rsc_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 32,
   parameter int ERR_W       = 5,
   parameter int BUS_SETTLE  = 3,
   parameter int ENG_SETTLE  = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eng_clk,
   input  logic              eng_rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              out_not_empty,
   input  logic              in_not_empty,
   input  logic              out_full,
   input  logic              out_done,
   input  logic              in_done,
   input  logic              out_svc_set,
   input  logic              in_svc_set,
   input  logic [ERR_W-1:0]  err_set,
   output logic              irq,
   output logic              flush_pulse,
   output logic              fifo_clear,
   output logic              eng_run,
   output logic              eng_pause
);
   generate
      if (BUS_SETTLE < 1)  begin : g_bad_bus  $error("BUS_SETTLE must be at least 1"); end
      if (ENG_SETTLE < 1)  begin : g_bad_eng  $error("ENG_SETTLE must be at least 1"); end
      if (SYNC_STAGES < 1) begin : g_bad_sync $error("SYNC_STAGES must be at least 1"); end
      if (DATA_W < 12)     begin : g_bad_data $error("DATA_W must hold bit 11"); end
      if (ERR_W < 1 || ERR_W > DATA_W) begin : g_bad_err $error("ERR_W out of range"); end
      if (ADDR_W < 2)      begin : g_bad_addr $error("ADDR_W must reach four registers"); end
   endgenerate

   logic       wr_state, wr_swrst, wr_oper, wr_err, swrst_wr;
   logic [1:0] code;
   logic       legal;
   logic       busy, valid;
   logic       launch, from_wr;
   run_state_e launch_code;
   run_state_e cur_st, tgt_st;
   logic       req_tgl, ack_tgl;
   logic       rst_pend_q;
   logic       flush_q, fclr_q;
   logic [1:0]       svc_q;
   logic [ERR_W-1:0] err_q;
   logic             err_any;

   assign wr_state = reg_wr && (reg_addr == ADDR_W'(A_STATE));
   assign wr_swrst = reg_wr && (reg_addr == ADDR_W'(A_SWRST));
   assign wr_oper  = reg_wr && (reg_addr == ADDR_W'(A_OPER));
   assign wr_err   = reg_wr && (reg_addr == ADDR_W'(A_ERR));
   assign swrst_wr = wr_swrst && reg_wdata[0];
   assign code     = reg_wdata[1:0];
   assign legal    = (code != CODE_ILLEGAL);
   assign valid    = ~busy;
   assign err_any  = |err_q;

   // Priority when idle: software reset, then error return, then a write.
   always_comb begin
      launch      = 1'b0;
      from_wr     = 1'b0;
      launch_code = ST_RESET;
      if (!busy) begin
         if (swrst_wr || rst_pend_q) begin
            launch = 1'b1;
         end else if (err_any && cur_st != ST_RESET) begin
            launch = 1'b1;
         end else if (wr_state && legal) begin
            launch      = 1'b1;
            from_wr     = 1'b1;
            launch_code = run_state_e'(code);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_pend_q <= 1'b0;
         flush_q    <= 1'b0;
         fclr_q     <= 1'b0;
      end else begin
         if (launch)                rst_pend_q <= 1'b0;
         else if (swrst_wr && busy) rst_pend_q <= 1'b1;
         flush_q <= launch && from_wr && reg_wdata[B_FLUSH];
         fclr_q  <= swrst_wr;
      end
   end

   rsc_seq #(
      .BUS_SETTLE  (BUS_SETTLE),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch      (launch),
      .launch_code (launch_code),
      .ack_tgl     (ack_tgl),
      .busy        (busy),
      .cur_st      (cur_st),
      .tgt_st      (tgt_st),
      .req_tgl     (req_tgl)
   );

   rsc_eng_side #(
      .ENG_SETTLE  (ENG_SETTLE),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_eng (
      .eng_clk   (eng_clk),
      .eng_rst_n (eng_rst_n),
      .req_tgl   (req_tgl),
      .tgt_st    (tgt_st),
      .ack_tgl   (ack_tgl),
      .run       (eng_run),
      .pause     (eng_pause)
   );

   rsc_flag_bank #(.W(2)) u_svc (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    ({in_svc_set, out_svc_set}),
      .w1c_we   (wr_oper),
      .w1c_mask (reg_wdata[B_IN_SVC:B_OUT_SVC]),
      .clr_all  (swrst_wr),
      .flags_q  (svc_q)
   );

   rsc_flag_bank #(.W(ERR_W)) u_err (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (err_set),
      .w1c_we   (wr_err),
      .w1c_mask (reg_wdata[ERR_W-1:0]),
      .clr_all  (swrst_wr),
      .flags_q  (err_q)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(A_STATE)) begin
         reg_rdata[1:0]     = cur_st;
         reg_rdata[B_VALID] = valid;
      end else if (reg_addr == ADDR_W'(A_OPER)) begin
         reg_rdata[B_OUT_NE]   = out_not_empty;
         reg_rdata[B_IN_NE]    = in_not_empty;
         reg_rdata[B_OUT_FULL] = out_full;
         reg_rdata[B_OUT_SVC]  = svc_q[0];
         reg_rdata[B_IN_SVC]   = svc_q[1];
         reg_rdata[B_OUT_DONE] = out_done;
         reg_rdata[B_IN_DONE]  = in_done;
      end else if (reg_addr == ADDR_W'(A_ERR)) begin
         reg_rdata[ERR_W-1:0] = err_q;
      end
   end

   assign irq         = err_any;
   assign flush_pulse = flush_q;
   assign fifo_clear  = fclr_q;
endmodule

// File: rtl/rsc_chk.sv
module rsc_chk #(
   parameter int ERR_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             valid,
   input logic [1:0]       cur_st,
   input logic [1:0]       tgt_st,
   input logic             wr_state,
   input logic [1:0]       code,
   input logic             swrst_wr,
   input logic             rst_pend,
   input logic [ERR_W-1:0] err_set,
   input logic             irq,
   input logic             flush_pulse,
   input logic             fifo_clear
);
   assert_no_code2_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cur_st != 2'd2);

   assert_illegal_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
      valid && wr_state && code == 2'd2 && !swrst_wr && !rst_pend
      && !(irq && cur_st != 2'd0) |=> valid);

   assert_write_drops_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      valid && wr_state && code != 2'd2 |=> !valid);

   assert_state_moves_with_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_st) |-> $rose(valid));

   assert_busy_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> $stable(tgt_st));

   assert_flush_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pulse |-> !valid ##1 !flush_pulse);

   assert_swrst_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      swrst_wr |=> fifo_clear && !irq);

   assert_err_raises_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_set) |=> irq);

   assert_err_forces_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      valid && irq && cur_st != 2'd0 |=> !valid);
endmodule

bind rsc_top rsc_chk #(.ERR_W(ERR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .valid       (valid),
   .cur_st      (cur_st),
   .tgt_st      (tgt_st),
   .wr_state    (wr_state),
   .code        (code),
   .swrst_wr    (swrst_wr),
   .rst_pend    (rst_pend_q),
   .err_set     (err_set),
   .irq         (irq),
   .flush_pulse (flush_pulse),
   .fifo_clear  (fifo_clear)
);

// File: tb/rsc_top_tb.sv
module rsc_top_tb;
   localparam int ERR_W = 5;
   localparam int BUS_SETTLE = 3;

   logic        clk = 1'b0, eng_clk = 1'b0;
   logic        rst_n = 1'b0, eng_rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        out_not_empty = 0, in_not_empty = 0, out_full = 0, out_done = 0, in_done = 0;
   logic        out_svc_set = 0, in_svc_set = 0;
   logic [ERR_W-1:0] err_set = '0;
   logic        irq, flush_pulse, fifo_clear, eng_run, eng_pause;

   int errors = 0, checks = 0;
   int flush_cnt = 0, fclr_cnt = 0;

   always #10 clk = ~clk;
   always #13 eng_clk = ~eng_clk;

   rsc_top #(.ERR_W(ERR_W), .BUS_SETTLE(BUS_SETTLE)) u_dut (
      .clk(clk), .rst_n(rst_n), .eng_clk(eng_clk), .eng_rst_n(eng_rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .out_not_empty(out_not_empty), .in_not_empty(in_not_empty), .out_full(out_full),
      .out_done(out_done), .in_done(in_done), .out_svc_set(out_svc_set),
      .in_svc_set(in_svc_set), .err_set(err_set), .irq(irq), .flush_pulse(flush_pulse),
      .fifo_clear(fifo_clear), .eng_run(eng_run), .eng_pause(eng_pause)
   );

   always @(posedge clk) begin
      if (flush_pulse) flush_cnt++;
      if (fifo_clear)  fclr_cnt++;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 32'(d);
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      reg_addr = 4'(a); #1;
      d = int'(reg_rdata);
   endtask

   task automatic wait_valid(output int n);
      int d;
      n = 0;
      @(negedge clk); rd(0, d);
      while (d[2] == 0 && n < 400) begin
         @(negedge clk); rd(0, d);
         n++;
      end
   endtask

   task automatic wait_quiet();
      int d, stable, guard;
      stable = 0; guard = 0;
      while (stable < 8 && guard < 1000) begin
         @(negedge clk); rd(0, d);
         if (d[2]) stable++; else stable = 0;
         guard++;
      end
   endtask

   task automatic goto_state(input int s);
      wr(0, s);
      wait_quiet();
   endtask

   initial begin
      #(20 * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int d, n, exp_st, f0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1; eng_rst_n = 1'b1;
      repeat (4) @(posedge clk);

      // R11 reset state
      @(negedge clk); rd(0, d);
      check("R11 state reg", d, 32'h4);
      rd(2, d); check("R11 oper reg", d, 0);
      rd(3, d); check("R11 err reg", d, 0);
      check("R11 irq", int'(irq), 0);
      check("R11 eng enables", int'({eng_run, eng_pause}), 0);

      // R1 R2 R3: sweep every start state against every written code
      for (int si = 0; si < 3; si++) begin
         for (int c = 0; c < 4; c++) begin
            int s;
            s = (si == 2) ? 3 : si;
            goto_state(s);
            wr(0, c);
            rd(0, d);
            if (c == 2) begin
               check("R1 code 2 keeps valid", d, 32'h4 | s);
               wait_quiet();
               rd(0, d);
               check("R1 code 2 keeps state", d, 32'h4 | s);
               exp_st = s;
            end else begin
               check("R2 valid low, old state held", d, s);
               wait_valid(n);
               check("R2 window length at least BUS_SETTLE", int'(n >= BUS_SETTLE), 1);
               rd(0, d);
               check("R2 new state shown", d, 32'h4 | c);
               exp_st = c;
            end
            check("R3 eng_run", int'(eng_run), int'(exp_st == 1));
            check("R3 eng_pause", int'(eng_pause), int'(exp_st == 3));
         end
      end

      // R4: write during window ignored
      goto_state(0);
      wr(0, 1);
      wr(0, 3);
      wait_quiet();
      rd(0, d);
      check("R4 busy write ignored", d, 32'h5);

      // R5: flush pulse
      f0 = flush_cnt;
      wr(0, 32'h41);
      wait_quiet();
      check("R5 one flush pulse", flush_cnt - f0, 1);
      f0 = flush_cnt;
      wr(0, 32'h01);
      wait_quiet();
      check("R5 no flush without bit 6", flush_cnt - f0, 0);

      // R7: live status sweep
      goto_state(0);
      for (int v = 0; v < 32; v++) begin
         @(negedge clk);
         out_not_empty = v[0]; in_not_empty = v[1]; out_full = v[2];
         out_done = v[3]; in_done = v[4];
         rd(2, d);
         check("R7 status bits", d,
               (v[0] << 4) | (v[1] << 5) | (v[2] << 6) | (v[3] << 10) | (v[4] << 11));
      end
      @(negedge clk);
      {out_not_empty, in_not_empty, out_full, out_done, in_done} = '0;

      // R8: service flags sticky, W1C
      for (int m = 0; m < 4; m++) begin
         @(posedge clk); #1 out_svc_set = 1; in_svc_set = 1;
         @(posedge clk); #1 out_svc_set = 0; in_svc_set = 0;
         rd(2, d);
         check("R8 service flags set", d, 32'h300);
         wr(2, m << 8);
         rd(2, d);
         check("R8 service W1C", d, (3 & ~m) << 8);
         wr(2, 32'h300);
      end

      // R9: each error source, W1C, irq
      for (int i = 0; i < ERR_W; i++) begin
         @(posedge clk); #1 err_set = ERR_W'(1 << i);
         @(posedge clk); #1 err_set = '0;
         rd(3, d);
         check("R9 error bit latched", d, 1 << i);
         check("R9 irq high", int'(irq), 1);
         wr(3, 0);
         rd(3, d);
         check("R9 write 0 keeps error", d, 1 << i);
         wr(3, 1 << i);
         check("R9 irq cleared", int'(irq), 0);
      end

      // R10: error in RUN forces RESET
      goto_state(1);
      @(posedge clk); #1 err_set = 5'b00100;
      @(posedge clk); #1 err_set = '0;
      @(posedge clk); #1;
      rd(0, d);
      check("R10 valid dropped", d & 4, 0);
      wait_quiet();
      rd(0, d);
      check("R10 state forced to RESET", d, 32'h4);
      check("R10 irq still set", int'(irq), 1);
      check("R10 engine stopped", int'({eng_run, eng_pause}), 0);
      wr(3, 32'h1f);

      // R6: software reset from RUN with flags pending
      goto_state(1);
      @(posedge clk); #1 out_svc_set = 1;
      @(posedge clk); #1 out_svc_set = 0;
      f0 = fclr_cnt;
      wr(1, 1);
      rd(2, d);
      check("R6 flags cleared", d, 0);
      wait_quiet();
      rd(0, d);
      check("R6 state RESET", d, 32'h4);
      check("R6 one fifo_clear pulse", fclr_cnt - f0, 1);

      // R6: software reset during a window is deferred, not lost
      goto_state(3);
      wr(0, 1);
      wr(1, 1);
      wait_quiet();
      rd(0, d);
      check("R6 deferred reset lands in RESET", d, 32'h4);
      check("R6 engine idle after deferred reset", int'({eng_run, eng_pause}), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule